// File: doc/BRIEF.md
# Heap Instantiation Forwarding Unit

This unit sits between the template instantiation stage of a graph-reduction processor and a heap memory with several ports. In each accepted cycle the instantiation stage hands over up to `MAX_APS` freshly built applications, each `AP_LEN` atoms wide. The unit gives them consecutive heap addresses taken from a running allocation pointer and writes all of them in the same cycle through parallel write ports. It also keeps a tagged copy of that cycle's applications for one accepted cycle.

Along with the applications, the stage presents the atom at the head of the new spine. When that atom is a pointer, the unit has to return the application it names on the following cycle. If the target was allocated by the template just accepted, the unit serves it from the forwarding copy, so a template can unwind a node that it is still allocating. Any other pointer requires a heap read. In that case the unit raises `stall` for exactly one cycle, borrows port 0 for the read and presents the returned data on the next cycle. Because conflicts are resolved at run time, every template may use all write ports.

Top module: `heap_fwd_unit`

## Requirements
- R1: After reset `stall`, `unwind_valid`, `heap_re` and every `heap_we` bit are 0. The allocation pointer starts at address 0, so the first accepted application is written to address 0.
- R2: In an accepted cycle with `inst_valid`=1 and `inst_count`=k, write ports 0..k-1 are enabled and no others. Port i carries application slot i of `inst_apps` (bits i*AP_LEN*ATOM_W upward).
- R3: Port i is given the address pointer+i. The pointer advances by k after each accepted cycle with `inst_valid`=1, and does not move otherwise. It wraps modulo 2^ADDR_W.
- R4: A pointer head is named by `head_kind`=3. With `head_local`=1 its address is the allocation pointer of that same template plus `head_value`. With `head_local`=0 the address is `head_value` itself.
- R5: If the pointer head names an application written by the same accepted template, the next cycle shows `unwind_valid`=1, `unwind_from_fwd`=1, the address and that application, with no stall.
- R6: Any other pointer head causes exactly one `stall` cycle on the next cycle. In that cycle `heap_re`=1 and port 0's address is the target. On the cycle after, `unwind_valid`=1, `unwind_from_fwd`=0 and `unwind_app` equals `heap_rdata`.
- R7: During a stall cycle, no write port is enabled and the presented inputs are not consumed, so the allocation pointer is unchanged. The same inputs are accepted in the following cycle.
- R8: A head atom with `head_kind` 0 (integer), 1 (constructor) or 2 (function) causes neither a stall nor an unwind.
- R9: A template that uses all `MAX_APS` write ports is accepted in full even when its head needs a heap read. The read takes place in the bubble cycle that follows.
- R10: The forwarding copy holds only the most recently accepted template. An accepted cycle with no applications empties it, and an older address is always fetched from the heap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inst_valid | input | 1 | New applications are presented |
| inst_count | input | $clog2(MAX_APS+1) | Number of applications presented |
| inst_apps | input | MAX_APS*AP_LEN*ATOM_W | Application slots, slot 0 lowest |
| head_valid | input | 1 | Spine head atom is presented |
| head_kind | input | 2 | Head kind: 0 int, 1 con, 2 fun, 3 pointer |
| head_local | input | 1 | Pointer is an index into this template's allocations |
| head_value | input | ADDR_W | Local index or absolute heap address |
| stall | output | 1 | Upstream must hold its outputs this cycle |
| heap_we | output | MAX_APS | Write enable per heap port |
| heap_addr | output | MAX_APS*ADDR_W | Address per heap port; port 0 also carries read address |
| heap_wdata | output | MAX_APS*AP_LEN*ATOM_W | Write data per heap port |
| heap_re | output | 1 | Read request on port 0 |
| heap_rdata | input | AP_LEN*ATOM_W | Port 0 read data, one cycle after `heap_re` |
| unwind_valid | output | 1 | Dereferenced application is presented |
| unwind_addr | output | ADDR_W | Address of the dereferenced application |
| unwind_app | output | AP_LEN*ATOM_W | Dereferenced application |
| unwind_from_fwd | output | 1 | Application was served from the forwarding copy |

## Verification
The assertions rely on a few properties of the surrounding system. `inst_count` never exceeds `MAX_APS`. The upstream stage keeps its outputs unchanged while `stall` is high. The heap returns port 0 read data exactly one cycle after `heap_re`. A local pointer index is smaller than the count of the same template, and absolute pointers name addresses that were written earlier. The stimulus follows these rules by construction. It holds every presentation across stall cycles, draws counts only in the range 0..MAX_APS, picks local indices below the count, and picks absolute targets only from addresses it has already written. The bench heap model answers reads after one cycle.

// File: rtl/hfu_pkg.sv
package hfu_pkg;

    localparam int DEF_MAX_APS = 3;
    localparam int DEF_AP_LEN  = 4;
    localparam int DEF_ATOM_W  = 12;
    localparam int DEF_ADDR_W  = 8;

    typedef enum logic [1:0] {
        KIND_INT = 2'd0,
        KIND_CON = 2'd1,
        KIND_FUN = 2'd2,
        KIND_PTR = 2'd3
    } atom_kind_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_FWD  = 2'd1,
        SRC_HEAP = 2'd2
    } unwind_src_e;

    function automatic logic needs_deref(input logic valid, input atom_kind_e kind);
        return valid && (kind == KIND_PTR);
    endfunction

endpackage

// File: rtl/hfu_fwd_store.sv
module hfu_fwd_store #(
    parameter int MAX_APS = hfu_pkg::DEF_MAX_APS,
    parameter int APP_W   = hfu_pkg::DEF_AP_LEN * hfu_pkg::DEF_ATOM_W,
    parameter int ADDR_W  = hfu_pkg::DEF_ADDR_W,
    parameter int CNT_W   = $clog2(MAX_APS + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     upd,
    input  logic                     fill,
    input  logic [CNT_W-1:0]         cnt,
    input  logic [ADDR_W-1:0]        base,
    input  logic [MAX_APS*APP_W-1:0] apps,
    input  logic [ADDR_W-1:0]        q_addr,
    output logic                     hit,
    output logic [APP_W-1:0]         hit_data
);

    logic [MAX_APS-1:0]  slot_vld;
    logic [ADDR_W-1:0]   slot_tag [MAX_APS];
    logic [APP_W-1:0]    slot_dat [MAX_APS];
    logic [MAX_APS-1:0]  match;

    for (genvar i = 0; i < MAX_APS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_vld[i] <= 1'b0;
                slot_tag[i] <= '0;
                slot_dat[i] <= '0;
            end else if (upd) begin
                slot_vld[i] <= fill && (CNT_W'(i) < cnt);
                slot_tag[i] <= base + ADDR_W'(i);
                slot_dat[i] <= apps[i*APP_W +: APP_W];
            end
        end
        assign match[i] = slot_vld[i] && (slot_tag[i] == q_addr);
    end

    always_comb begin
        hit_data = '0;
        for (int i = 0; i < MAX_APS; i++) begin
            if (match[i]) hit_data = hit_data | slot_dat[i];
        end
    end

    assign hit = |match;

endmodule

// File: rtl/hfu_port_drive.sv
module hfu_port_drive #(
    parameter int MAX_APS = hfu_pkg::DEF_MAX_APS,
    parameter int APP_W   = hfu_pkg::DEF_AP_LEN * hfu_pkg::DEF_ATOM_W,
    parameter int ADDR_W  = hfu_pkg::DEF_ADDR_W,
    parameter int CNT_W   = $clog2(MAX_APS + 1)
) (
    input  logic                      accept,
    input  logic                      fill,
    input  logic [CNT_W-1:0]          cnt,
    input  logic [ADDR_W-1:0]         base,
    input  logic [MAX_APS*APP_W-1:0]  apps,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    output logic [MAX_APS-1:0]        we,
    output logic [MAX_APS*ADDR_W-1:0] addr,
    output logic [MAX_APS*APP_W-1:0]  wdata
);

    for (genvar i = 0; i < MAX_APS; i++) begin : g_port
        logic [ADDR_W-1:0] wr_addr;
        assign wr_addr = base + ADDR_W'(i);
        assign we[i]   = accept && fill && (CNT_W'(i) < cnt);
        assign wdata[i*APP_W +: APP_W] = apps[i*APP_W +: APP_W];
        if (i == 0) begin : g_shared
            assign addr[ADDR_W-1:0] = rd_en ? rd_addr : wr_addr;
        end else begin : g_write_only
            assign addr[i*ADDR_W +: ADDR_W] = wr_addr;
        end
    end

endmodule

// File: rtl/hfu_unwind_ctl.sv
module hfu_unwind_ctl #(
    parameter int ADDR_W = hfu_pkg::DEF_ADDR_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                head_valid,
    input  logic [1:0]          head_kind,
    input  logic                head_local,
    input  logic [ADDR_W-1:0]   head_value,
    input  logic [ADDR_W-1:0]   base,
    input  logic                fwd_hit,
    output logic [ADDR_W-1:0]   pend_addr,
    output logic                stall,
    output logic                rd_en,
    output logic                unwind_valid,
    output hfu_pkg::unwind_src_e src
);
    import hfu_pkg::*;

    logic pend_vld;
    logic rd_wait;
    logic want;

    assign want  = needs_deref(head_valid, atom_kind_e'(head_kind));
    assign stall = pend_vld && !rd_wait && !fwd_hit;
    assign rd_en = stall;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld  <= 1'b0;
            pend_addr <= '0;
            rd_wait   <= 1'b0;
        end else if (stall) begin
            rd_wait <= 1'b1;
        end else begin
            rd_wait   <= 1'b0;
            pend_vld  <= want;
            pend_addr <= head_local ? (base + head_value) : head_value;
        end
    end

    always_comb begin
        unwind_valid = pend_vld && (rd_wait || fwd_hit);
        if (!unwind_valid) src = SRC_NONE;
        else if (rd_wait)  src = SRC_HEAP;
        else               src = SRC_FWD;
    end

endmodule

// File: rtl/heap_fwd_unit.sv
module heap_fwd_unit #(
    parameter int MAX_APS = hfu_pkg::DEF_MAX_APS,
    parameter int AP_LEN  = hfu_pkg::DEF_AP_LEN,
    parameter int ATOM_W  = hfu_pkg::DEF_ATOM_W,
    parameter int ADDR_W  = hfu_pkg::DEF_ADDR_W
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              inst_valid,
    input  logic [$clog2(MAX_APS+1)-1:0]      inst_count,
    input  logic [MAX_APS*AP_LEN*ATOM_W-1:0]  inst_apps,
    input  logic                              head_valid,
    input  logic [1:0]                        head_kind,
    input  logic                              head_local,
    input  logic [ADDR_W-1:0]                 head_value,
    output logic                              stall,
    output logic [MAX_APS-1:0]                heap_we,
    output logic [MAX_APS*ADDR_W-1:0]         heap_addr,
    output logic [MAX_APS*AP_LEN*ATOM_W-1:0]  heap_wdata,
    output logic                              heap_re,
    input  logic [AP_LEN*ATOM_W-1:0]          heap_rdata,
    output logic                              unwind_valid,
    output logic [ADDR_W-1:0]                 unwind_addr,
    output logic [AP_LEN*ATOM_W-1:0]          unwind_app,
    output logic                              unwind_from_fwd
);
    import hfu_pkg::*;

    localparam int APP_W = AP_LEN * ATOM_W;
    localparam int CNT_W = $clog2(MAX_APS + 1);

    logic [ADDR_W-1:0] alloc_ptr;
    logic              accept;
    logic              fwd_hit;
    logic [APP_W-1:0]  fwd_data;
    logic [ADDR_W-1:0] pend_addr;
    unwind_src_e       src;

    assign accept = !stall;

    always_ff @(posedge clk) begin
        if (rst)                       alloc_ptr <= '0;
        else if (accept && inst_valid) alloc_ptr <= alloc_ptr + ADDR_W'(inst_count);
    end

    hfu_fwd_store #(
        .MAX_APS(MAX_APS), .APP_W(APP_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_store (
        .clk(clk), .rst(rst), .upd(accept), .fill(inst_valid), .cnt(inst_count),
        .base(alloc_ptr), .apps(inst_apps), .q_addr(pend_addr),
        .hit(fwd_hit), .hit_data(fwd_data)
    );

    hfu_port_drive #(
        .MAX_APS(MAX_APS), .APP_W(APP_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
    ) u_ports (
        .accept(accept), .fill(inst_valid), .cnt(inst_count), .base(alloc_ptr),
        .apps(inst_apps), .rd_en(heap_re), .rd_addr(pend_addr),
        .we(heap_we), .addr(heap_addr), .wdata(heap_wdata)
    );

    hfu_unwind_ctl #(.ADDR_W(ADDR_W)) u_ctl (
        .clk(clk), .rst(rst), .head_valid(head_valid), .head_kind(head_kind),
        .head_local(head_local), .head_value(head_value), .base(alloc_ptr),
        .fwd_hit(fwd_hit), .pend_addr(pend_addr), .stall(stall), .rd_en(heap_re),
        .unwind_valid(unwind_valid), .src(src)
    );

    assign unwind_addr     = pend_addr;
    assign unwind_from_fwd = (src == SRC_FWD);
    assign unwind_app      = (src == SRC_HEAP) ? heap_rdata : fwd_data;

endmodule

// File: rtl/hfu_checker.sv
module hfu_checker #(
    parameter int MAX_APS = hfu_pkg::DEF_MAX_APS
) (
    input logic               clk,
    input logic               rst,
    input logic               stall,
    input logic               heap_re,
    input logic [MAX_APS-1:0] heap_we,
    input logic               unwind_valid,
    input logic               unwind_from_fwd
);

    logic [MAX_APS:0] we_ext;
    assign we_ext = {1'b0, heap_we};

    assert_stall_single_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    assert_stall_reads_R6: assert property (@(posedge clk) disable iff (rst)
        stall |-> heap_re);

    assert_stall_then_heap_R6: assert property (@(posedge clk) disable iff (rst)
        stall |=> (unwind_valid && !unwind_from_fwd));

    assert_stall_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        stall |-> (heap_we == '0));

    assert_we_prefix_R2: assert property (@(posedge clk) disable iff (rst)
        ((we_ext & (we_ext + 1'b1)) == '0));

    assert_unwind_no_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        unwind_valid |-> !stall);

endmodule

bind heap_fwd_unit hfu_checker #(.MAX_APS(MAX_APS)) u_hfu_checker (
    .clk(clk), .rst(rst), .stall(stall), .heap_re(heap_re), .heap_we(heap_we),
    .unwind_valid(unwind_valid), .unwind_from_fwd(unwind_from_fwd)
);

// File: tb/test_heap_fwd_unit.sv
`timescale 1ns/1ps
module test_heap_fwd_unit;

    localparam int MAX_APS = 3;
    localparam int AP_LEN  = 4;
    localparam int ATOM_W  = 12;
    localparam int ADDR_W  = 8;
    localparam int APP_W   = AP_LEN * ATOM_W;
    localparam int CNT_W   = $clog2(MAX_APS + 1);
    localparam int DEPTH   = 1 << ADDR_W;

    typedef struct {
        int              addr;
        logic [APP_W-1:0] data;
        bit              fwd;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic inst_valid = 1'b0;
    logic [CNT_W-1:0] inst_count = '0;
    logic [MAX_APS*APP_W-1:0] inst_apps = '0;
    logic head_valid = 1'b0;
    logic [1:0] head_kind = '0;
    logic head_local = 1'b0;
    logic [ADDR_W-1:0] head_value = '0;
    logic stall, heap_re, unwind_valid, unwind_from_fwd;
    logic [MAX_APS-1:0] heap_we;
    logic [MAX_APS*ADDR_W-1:0] heap_addr;
    logic [MAX_APS*APP_W-1:0] heap_wdata;
    logic [APP_W-1:0] heap_rdata;
    logic [ADDR_W-1:0] unwind_addr;
    logic [APP_W-1:0] unwind_app;

    always #4 clk = ~clk;

    heap_fwd_unit #(.MAX_APS(MAX_APS), .AP_LEN(AP_LEN), .ATOM_W(ATOM_W), .ADDR_W(ADDR_W)) i_heap_fwd_unit (
        .clk(clk), .rst(rst), .inst_valid(inst_valid), .inst_count(inst_count),
        .inst_apps(inst_apps), .head_valid(head_valid), .head_kind(head_kind),
        .head_local(head_local), .head_value(head_value), .stall(stall),
        .heap_we(heap_we), .heap_addr(heap_addr), .heap_wdata(heap_wdata),
        .heap_re(heap_re), .heap_rdata(heap_rdata), .unwind_valid(unwind_valid),
        .unwind_addr(unwind_addr), .unwind_app(unwind_app), .unwind_from_fwd(unwind_from_fwd)
    );

    // heap memory model: writes on all ports, one-cycle read on port 0
    logic [APP_W-1:0] heap_mem [DEPTH];
    always @(posedge clk) begin
        for (int p = 0; p < MAX_APS; p++)
            if (heap_we[p]) heap_mem[heap_addr[p*ADDR_W +: ADDR_W]] <= heap_wdata[p*APP_W +: APP_W];
        if (heap_re) heap_rdata <= heap_mem[heap_addr[ADDR_W-1:0]];
    end

    int errors = 0;
    int checks = 0;
    bit done = 0;
    exp_t sb[$];

    logic [APP_W-1:0] m_mem [DEPTH];
    int m_ptr = 0;
    int exp_stalls = 0;
    int exp_rd_addr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [APP_W-1:0] mk_app(input int seed, input int slot);
        logic [APP_W-1:0] a;
        for (int j = 0; j < AP_LEN; j++)
            a[j*ATOM_W +: ATOM_W] = ATOM_W'(seed * 37 + slot * 5 + j * 3 + 1);
        return a;
    endfunction

    // driver: presents one template, holds it across stalls, pushes expectations
    task automatic present(input bit iv, input int cnt, input int seed, input bit hv,
                           input int kind, input bit loc, input int val);
        logic [MAX_APS*APP_W-1:0] apps;
        int stalls = 0;
        int eff;
        eff = iv ? cnt : 0;
        for (int i = 0; i < MAX_APS; i++) apps[i*APP_W +: APP_W] = mk_app(seed, i);
        @(negedge clk);
        inst_valid = iv; inst_count = CNT_W'(cnt); inst_apps = apps;
        head_valid = hv; head_kind = 2'(kind); head_local = loc; head_value = ADDR_W'(val);
        #1;
        while (stall === 1'b1 && stalls < 4) begin
            stalls++;
            chk(heap_we == '0, "R7", "write during stall", 64'(heap_we), 0);
            chk(heap_re === 1'b1, "R6", "heap_re in stall", 64'(heap_re), 1);
            chk(int'(heap_addr[ADDR_W-1:0]) == exp_rd_addr, "R6", "read address",
                64'(heap_addr[ADDR_W-1:0]), 64'(exp_rd_addr));
            @(negedge clk); #1;
        end
        chk(stalls == exp_stalls, exp_stalls ? "R6" : "R5", "stall cycles",
            64'(stalls), 64'(exp_stalls));
        chk(heap_we == MAX_APS'((1 << eff) - 1), "R2", "write enables",
            64'(heap_we), 64'((1 << eff) - 1));
        for (int i = 0; i < eff; i++) begin
            chk(int'(heap_addr[i*ADDR_W +: ADDR_W]) == (m_ptr + i) % DEPTH, "R3", "write address",
                64'(heap_addr[i*ADDR_W +: ADDR_W]), 64'((m_ptr + i) % DEPTH));
            chk(heap_wdata[i*APP_W +: APP_W] == apps[i*APP_W +: APP_W], "R2", "write data",
                64'(heap_wdata[i*APP_W +: APP_W]), 64'(apps[i*APP_W +: APP_W]));
        end
        for (int i = 0; i < eff; i++) m_mem[(m_ptr + i) % DEPTH] = apps[i*APP_W +: APP_W];
        exp_stalls = 0;
        if (hv && kind == 3) begin
            exp_t e;
            int hit_slot = -1;
            e.addr = loc ? (m_ptr + val) % DEPTH : val;  // R4
            for (int i = 0; i < eff; i++) if ((m_ptr + i) % DEPTH == e.addr) hit_slot = i;
            e.fwd  = (hit_slot >= 0);
            e.data = m_mem[e.addr];
            sb.push_back(e);
            exp_stalls  = e.fwd ? 0 : 1;
            exp_rd_addr = e.addr;
        end
        m_ptr = (m_ptr + eff) % DEPTH;
        @(posedge clk);
    endtask

    // monitor: pops scoreboard on each unwind
    initial begin
        forever begin
            @(negedge clk); #2;
            if (!rst && unwind_valid === 1'b1) begin
                if (sb.size() == 0) begin
                    chk(0, "R8", "unexpected unwind", 64'(unwind_addr), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(int'(unwind_addr) == e.addr, "R4", "unwind address",
                        64'(unwind_addr), 64'(e.addr));
                    chk(unwind_app == e.data, e.fwd ? "R5" : "R6", "unwind data",
                        64'(unwind_app), 64'(e.data));
                    chk(unwind_from_fwd == e.fwd, e.fwd ? "R5" : "R10", "unwind source",
                        64'(unwind_from_fwd), 64'(e.fwd));
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            chk(0, "R6", "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(stall == 1'b0, "R1", "stall after reset", 64'(stall), 0);
        chk(unwind_valid == 1'b0, "R1", "unwind after reset", 64'(unwind_valid), 0);
        chk(heap_re == 1'b0, "R1", "heap_re after reset", 64'(heap_re), 0);
        chk(heap_we == '0, "R1", "we after reset", 64'(heap_we), 0);

        // R1 R5 own-allocated head, forwarded
        present(1, 3, 1, 1, 3, 1, 0);
        // R8 function head, no stall after a hit
        present(1, 2, 2, 1, 2, 0, 0);
        // R5 local index to last slot
        present(1, 3, 3, 1, 3, 1, 2);
        // R9 full allocation with a miss to an old address
        present(1, 3, 4, 1, 3, 0, 1);
        // R8 integer and constructor heads
        present(1, 1, 5, 1, 0, 0, 7);
        present(1, 2, 6, 1, 1, 0, 0);
        // R10 empty accepted cycle flushes the forwarding copy
        present(0, 0, 7, 1, 3, 0, m_ptr - 1);
        // R7 R3 count ignored without inst_valid, back-to-back misses
        present(0, 3, 8, 1, 3, 0, 2);
        present(1, 2, 9, 1, 3, 0, 5);
        // R3 invalid head, no unwind
        present(1, 3, 10, 0, 3, 1, 0);
        for (int t = 0; t < 40; t++) begin
            int c, k, v;
            bit l;
            c = $urandom_range(0, MAX_APS);
            k = $urandom_range(0, 3);
            l = (c > 0) && ($urandom_range(0, 1) == 1);
            if (l) v = $urandom_range(0, c - 1);
            else   v = (m_ptr - 1 - $urandom_range(0, 5) + DEPTH) % DEPTH;
            present(1, c, 20 + t, 1, k, l, v);
        end
        present(1, 0, 99, 0, 0, 0, 0);
        present(1, 0, 99, 0, 0, 0, 0);
        repeat (2) @(negedge clk);
        chk(sb.size() == 0, "R6", "scoreboard drained", 64'(sb.size()), 0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule